// File: doc/BRIEF.md
# Range Cache Maintenance Engine

This block carries out one cache maintenance operation over a span of physical addresses. Software writes a start address and an exclusive end address, then writes the control word with a start bit and an operation code. The engine then walks the span one 64-byte line at a time. For every line it presents the line address and the operation code on a valid/ready request port toward the cache. Every line that overlaps the span is covered.

The control word reports progress. Its busy bit stays set while the walk runs and falls by itself once the last line has been taken, so software polls it. Three operations exist: clean and invalidate, invalidate without write-back, and clean to shared. The fourth code is reserved; starting with it raises an error flag and issues nothing. While a walk is in progress the register file refuses every write, so a running operation cannot be disturbed.

The cache arrays, the coherence fabric and the bus bridge lie outside the block. The register port is a plain single-cycle write strobe with a combinational read.

Top module: `range_maint_engine`

## Requirements
- R1: The start register sits at byte offset 0x00 and the end register at 0x08. Each keeps only bits 39:0 of the written word and reads back zero above bit 39. Offset 0x10 is the control word; every other offset reads zero.
- R2: The control word reads back busy in bit 0, the latched operation code in bits 2:1 and the error flag in bit 3, with all other bits zero. A control write with bit 0 set while idle starts an operation and latches bits 2:1. A control write with bit 0 clear changes nothing.
- R3: The first request carries the start address rounded down to a multiple of 64. Each following request is 64 higher. The last request is the line that holds byte end-1, so each line overlapping [start, end) is requested exactly once.
- R4: Every request carries the latched operation code: 0 = clean and invalidate, 1 = invalidate only, 2 = clean to shared. Code 3 never appears on the request port.
- R5: A request that is not taken (valid high, ready low) is held unchanged with the same address and code on the next cycle. The walk advances only on a cycle where valid and ready are both high.
- R6: After the clock edge that takes the last request, busy still reads 1 for one cycle and reads 0 from the following edge on.
- R7: When end <= start, no request is issued; busy reads 1 for one cycle after the starting edge and 0 after the next edge.
- R8: Starting with code 3 issues no request, keeps busy for one cycle like R7, and sets the error flag. The next start clears the flag, which is then set again only if that start also uses code 3.
- R9: While busy, writes to the start, end and control registers are ignored: the values read back and the operation in progress stay as they were.
- R10: A synchronous active-low reset clears both address registers, the latched code and the error flag, ends any walk and drops the request valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Register write strobe, one cycle per write |
| cfg_addr | input | 5 | Register byte offset |
| cfg_wdata | input | 64 | Register write data |
| cfg_rdata | output | 64 | Register read data for cfg_addr (combinational) |
| req_valid | output | 1 | A line request is presented |
| req_ready | input | 1 | The cache takes the request on this edge |
| req_line_addr | output | 40 | 64-byte-aligned line address |
| req_op | output | 2 | Operation code for the line |

## Verification
The assertions watch, on every cycle, how the request port behaves locally. They check that a stalled request holds its address and code, that each taken request is followed by either no request or one 64 bytes higher, that code 3 never leaves the block, that an error state issues nothing, and that the address registers and the latched code stay frozen while busy. Other behaviours depend on the whole operation and only the bench's scenarios can show them. These are the exact first and last line for unaligned and boundary spans, the total line count, the one-cycle delay before busy falls, the handling of empty and reversed ranges, the masking of the upper address bits, and the setting and clearing of the error flag across operations.

// File: rtl/rme_pkg.sv
// Shared types and register layout for the range cache maintenance engine.
// Assumes byte offsets on the register port and a 64-bit register word.
package rme_pkg;

    // Operation codes carried in control bits 2:1 and on the request port.
    typedef enum logic [1:0] {
        OP_CLEAN_INV    = 2'd0,
        OP_INV_ONLY     = 2'd1,
        OP_CLEAN_SHARED = 2'd2,
        OP_RESERVED     = 2'd3
    } maint_op_e;

    // Sequencer states: idle, issuing lines, one trailing busy cycle.
    typedef enum logic [1:0] {
        WS_IDLE = 2'd0,
        WS_WALK = 2'd1,
        WS_DONE = 2'd2
    } walk_state_e;

    // Register byte offsets.
    localparam int unsigned OFS_START = 0;
    localparam int unsigned OFS_END   = 8;
    localparam int unsigned OFS_CTRL  = 16;

    // Control word bit positions.
    localparam int unsigned CTL_BUSY_BIT = 0;
    localparam int unsigned CTL_MODE_LSB = 1;
    localparam int unsigned CTL_ERR_BIT  = 3;

endpackage

// File: rtl/rme_regfile.sv
// Register file: holds the start and end addresses, decodes the start
// command and builds the read data. Assumes DATA_W > ADDR_W and that
// DATA_W > CTL_ERR_BIT. Every write is refused while busy is high.
module rme_regfile
    import rme_pkg::*;
#(
    parameter int unsigned ADDR_W = 40,
    parameter int unsigned DATA_W = 64,
    parameter int unsigned REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              busy,
    input  logic              err,
    input  logic [1:0]        mode_rb,
    output logic [ADDR_W-1:0] start_q,
    output logic [ADDR_W-1:0] end_q,
    output logic              go,
    output maint_op_e         go_mode
);

    localparam logic [REG_AW-1:0] A_START = REG_AW'(OFS_START);
    localparam logic [REG_AW-1:0] A_END   = REG_AW'(OFS_END);
    localparam logic [REG_AW-1:0] A_CTRL  = REG_AW'(OFS_CTRL);

    logic wr_start;
    logic wr_end;
    logic unused_wdata_hi;

    // Write qualifiers: a register takes a write only while the engine is idle.
    assign wr_start = cfg_we && (cfg_addr == A_START) && !busy;
    assign wr_end   = cfg_we && (cfg_addr == A_END)   && !busy;

    // Start command: control write with the start bit set while idle.
    assign go      = cfg_we && (cfg_addr == A_CTRL) && cfg_wdata[CTL_BUSY_BIT] && !busy;
    assign go_mode = maint_op_e'(cfg_wdata[CTL_MODE_LSB +: 2]);

    // Bits above the physical address width are dropped on purpose.
    assign unused_wdata_hi = ^cfg_wdata[DATA_W-1:ADDR_W];

    // Start address register, masked to the physical address width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
        end else if (wr_start) begin
            start_q <= cfg_wdata[ADDR_W-1:0];
        end
    end

    // End address register, masked to the physical address width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_q <= '0;
        end else if (wr_end) begin
            end_q <= cfg_wdata[ADDR_W-1:0];
        end
    end

    // Read multiplexer: address registers, live control word, zero elsewhere.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            A_START: cfg_rdata[ADDR_W-1:0] = start_q;
            A_END:   cfg_rdata[ADDR_W-1:0] = end_q;
            A_CTRL: begin
                cfg_rdata[CTL_BUSY_BIT]      = busy;
                cfg_rdata[CTL_MODE_LSB +: 2] = mode_rb;
                cfg_rdata[CTL_ERR_BIT]       = err;
            end
            default: cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rme_line_span.sv
// Line span calculator: turns a byte range [start, end) into the index of
// the first and last 64-byte line and an empty flag. Purely combinational.
// Assumes LINE_BYTES is a power of two smaller than 2**ADDR_W.
module rme_line_span #(
    parameter int unsigned ADDR_W     = 40,
    parameter int unsigned LINE_BYTES = 64,
    localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
    localparam int unsigned IDX_W     = ADDR_W - OFF_W
) (
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] end_addr,
    output logic [IDX_W-1:0]  first_idx,
    output logic [IDX_W-1:0]  last_idx,
    output logic              empty
);

    logic [ADDR_W-1:0] last_byte;
    logic              unused_line_offsets;

    // An exclusive end at or below the start covers no byte at all.
    assign empty = (end_addr <= start_addr);

    // The last covered byte; only meaningful when the span is not empty.
    assign last_byte = end_addr - ADDR_W'(1);

    // Line indices: drop the offset inside the line.
    assign first_idx = start_addr[ADDR_W-1:OFF_W];
    assign last_idx  = last_byte[ADDR_W-1:OFF_W];

    // Offsets within a line do not matter for the walk.
    assign unused_line_offsets = ^{start_addr[OFF_W-1:0], last_byte[OFF_W-1:0]};

endmodule

// File: rtl/rme_line_walker.sv
// Line walker: latches the operation on a start command and issues one
// request per line from first_idx to last_idx. It advances on each taken
// request and keeps busy for one extra cycle after the last one. Empty
// spans and the reserved code skip straight to that trailing cycle.
// Assumes go is only raised while busy is low.
module rme_line_walker
    import rme_pkg::*;
#(
    parameter int unsigned ADDR_W     = 40,
    parameter int unsigned LINE_BYTES = 64,
    localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
    localparam int unsigned IDX_W     = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  maint_op_e         go_mode,
    input  logic [IDX_W-1:0]  first_idx,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic              empty,
    output logic              busy,
    output logic              err,
    output logic [1:0]        mode_rb,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_line_addr,
    output logic [1:0]        req_op
);

    walk_state_e      state_q;
    maint_op_e        mode_q;
    logic [IDX_W-1:0] cur_idx_q;
    logic [IDX_W-1:0] end_idx_q;
    logic             take;
    logic             at_last;
    logic             bad_mode;

    assign take     = req_valid && req_ready;
    assign at_last  = (cur_idx_q == end_idx_q);
    assign bad_mode = (go_mode == OP_RESERVED);

    // Sequencer state: idle -> walk (or straight to done) -> done -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
        end else begin
            case (state_q)
                WS_IDLE: if (go) state_q <= (bad_mode || empty) ? WS_DONE : WS_WALK;
                WS_WALK: if (take && at_last) state_q <= WS_DONE;
                WS_DONE: state_q <= WS_IDLE;
                default: state_q <= WS_IDLE;
            endcase
        end
    end

    // Line cursor: loaded at start, stepped by one line on each taken request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_idx_q <= '0;
            end_idx_q <= '0;
        end else if (state_q == WS_IDLE && go) begin
            cur_idx_q <= first_idx;
            end_idx_q <= last_idx;
        end else if (state_q == WS_WALK && take && !at_last) begin
            cur_idx_q <= cur_idx_q + IDX_W'(1);
        end
    end

    // Operation code and error flag: both change only on a start command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= OP_CLEAN_INV;
            err    <= 1'b0;
        end else if (state_q == WS_IDLE && go) begin
            mode_q <= go_mode;
            err    <= bad_mode;
        end
    end

    // Port drive: a request is presented for the whole walk state.
    assign busy          = (state_q != WS_IDLE);
    assign req_valid     = (state_q == WS_WALK);
    assign req_line_addr = {cur_idx_q, {OFF_W{1'b0}}};
    assign req_op        = mode_q;
    assign mode_rb       = mode_q;

endmodule

// File: rtl/range_maint_engine.sv
// Range cache maintenance engine top. Joins the register file, the line span
// calculator and the line walker. Software programs start and end, writes the
// control word to start, and polls the busy bit. Assumes a cache port that
// takes a request on any edge where valid and ready are both high.
module range_maint_engine
    import rme_pkg::*;
#(
    parameter int unsigned ADDR_W     = 40,
    parameter int unsigned DATA_W     = 64,
    parameter int unsigned REG_AW     = 5,
    parameter int unsigned LINE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [REG_AW-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_line_addr,
    output logic [1:0]        req_op
);

    localparam int unsigned OFF_W = $clog2(LINE_BYTES);
    localparam int unsigned IDX_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] start_q_w;
    logic [ADDR_W-1:0] end_q_w;
    logic [IDX_W-1:0]  first_idx_w;
    logic [IDX_W-1:0]  last_idx_w;
    logic              empty_w;
    logic              go_w;
    maint_op_e         go_mode_w;
    logic              busy_w;
    logic              err_w;
    logic [1:0]        mode_rb_w;

    // Software-visible registers and start decode.
    rme_regfile #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .REG_AW (REG_AW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .busy      (busy_w),
        .err       (err_w),
        .mode_rb   (mode_rb_w),
        .start_q   (start_q_w),
        .end_q     (end_q_w),
        .go        (go_w),
        .go_mode   (go_mode_w)
    );

    // First and last line of the programmed span.
    rme_line_span #(
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES)
    ) u_span (
        .start_addr (start_q_w),
        .end_addr   (end_q_w),
        .first_idx  (first_idx_w),
        .last_idx   (last_idx_w),
        .empty      (empty_w)
    );

    // Request sequencer.
    rme_line_walker #(
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES)
    ) u_walk (
        .clk           (clk),
        .rst_n         (rst_n),
        .go            (go_w),
        .go_mode       (go_mode_w),
        .first_idx     (first_idx_w),
        .last_idx      (last_idx_w),
        .empty         (empty_w),
        .busy          (busy_w),
        .err           (err_w),
        .mode_rb       (mode_rb_w),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_line_addr (req_line_addr),
        .req_op        (req_op)
    );

endmodule

// File: rtl/rme_checker.sv
// Protocol and state checker for the range cache maintenance engine,
// attached to every instance of the top module by the bind below.
module rme_checker #(
    parameter int unsigned ADDR_W     = 40,
    parameter int unsigned REG_AW     = 5,
    parameter int unsigned LINE_BYTES = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [REG_AW-1:0] cfg_addr,
    input logic              busy,
    input logic              err,
    input logic [ADDR_W-1:0] start_q,
    input logic [ADDR_W-1:0] end_q,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_line_addr,
    input logic [1:0]        req_op
);

    // R5: a stalled request is held unchanged.
    a_r5_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_line_addr) && $stable(req_op));

    // R5: a request is only presented during an operation.
    a_r5_valid_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> busy);

    // R3: after a taken request comes either nothing or the next line.
    a_r3_step_one_line: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_valid ||
            (req_line_addr == $past(req_line_addr) + ADDR_W'(LINE_BYTES)));

    // R4: the reserved code never reaches the cache.
    a_r4_no_reserved_op: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_op != 2'd3);

    // R8: an operation that raised the error issues nothing.
    a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !req_valid);

    // R9: address registers are frozen while busy.
    a_r9_start_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cfg_we && cfg_addr == REG_AW'(0) |=> $stable(start_q));

    a_r9_end_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cfg_we && cfg_addr == REG_AW'(8) |=> $stable(end_q));

    // R9: the latched operation cannot change during a walk.
    a_r9_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(req_op));

endmodule

bind range_maint_engine rme_checker #(
    .ADDR_W     (ADDR_W),
    .REG_AW     (REG_AW),
    .LINE_BYTES (LINE_BYTES)
) u_rme_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_addr      (cfg_addr),
    .busy          (busy_w),
    .err           (err_w),
    .start_q       (start_q_w),
    .end_q         (end_q_w),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_line_addr (req_line_addr),
    .req_op        (req_op)
);

// File: tb/range_maint_engine_bench.sv
`timescale 1ns/1ps
module range_maint_engine_bench;

    localparam int NV = 8;
    localparam logic [63:0] MASK40 = 64'h0000_00FF_FFFF_FFFF;

    // Vector table: raw start, raw end, code, ready pattern, line count, first line.
    localparam logic [63:0] V_START [NV] = '{
        64'h1000, 64'h2010, 64'h3000, 64'hFF_FFFF_FF80,
        64'h5000, 64'h6000, 64'h7040, 64'hAB00_0000_0000_1000 };
    localparam logic [63:0] V_END [NV] = '{
        64'h1100, 64'h2050, 64'h3001, 64'hFF_FFFF_FFFF,
        64'h5000, 64'h5000, 64'h7240, 64'hCD00_0000_0000_1080 };
    localparam logic [1:0] V_MODE [NV] = '{ 2'd0, 2'd1, 2'd2, 2'd0, 2'd0, 2'd1, 2'd2, 2'd1 };
    localparam logic [7:0] V_RDY  [NV] = '{ 8'hFF, 8'h55, 8'h11, 8'hF0, 8'hFF, 8'hFF, 8'h6D, 8'hFE };
    localparam int         V_N    [NV] = '{ 4, 2, 1, 2, 0, 0, 8, 2 };
    localparam logic [39:0] V_FIRST [NV] = '{
        40'h1000, 40'h2000, 40'h3000, 40'hFF_FFFF_FF80,
        40'h0, 40'h0, 40'h7040, 40'h1000 };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [63:0] cfg_wdata = '0;
    logic [63:0] cfg_rdata;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [39:0] req_line_addr;
    logic [1:0]  req_op;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    range_maint_engine u_range_maint_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_addr      (cfg_addr),
        .cfg_wdata     (cfg_wdata),
        .cfg_rdata     (cfg_rdata),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_line_addr (req_line_addr),
        .req_op        (req_op)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One register write; called and returning at a falling edge.
    task automatic wr(input logic [4:0] a, input logic [63:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [63:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    // Serve requests until busy falls; check sequence, count, timing and status.
    task automatic drain(input logic [1:0] mode, input logic [39:0] first, input int exp_n,
                         input logic [7:0] rdy, input bit exp_err, input string tag);
        int n = 0;
        int last_acc = -1;
        int done_cyc = -1;
        bit seq_ok = 1'b1;
        bit op_ok = 1'b1;
        logic [39:0] exp_a;
        logic [39:0] bad_a = '0;
        cfg_addr = 5'h10;
        for (int cyc = 0; cyc < 600; cyc++) begin
            #1;
            if (cfg_rdata[0] == 1'b0) begin
                done_cyc = cyc;
                break;
            end
            req_ready = rdy[cyc % 8];
            #1;
            if (req_valid && req_op != mode) op_ok = 1'b0;
            if (req_valid && req_ready) begin
                exp_a = first + 40'(64 * n);
                if (req_line_addr != exp_a) begin
                    seq_ok = 1'b0;
                    bad_a = req_line_addr;
                end
                n++;
                last_acc = cyc;
            end
            @(negedge clk);
        end
        req_ready = 1'b0;
        chk(seq_ok, {tag, " R3 line sequence"}, 64'(bad_a), 64'(first));
        chk(n == exp_n, {tag, " R3 line count"}, 64'(n), 64'(exp_n));
        chk(op_ok, {tag, " R4 request code"}, 64'(req_op), 64'(mode));
        if (exp_n == 0)
            chk(done_cyc == 1, {tag, " R7 R8 busy one cycle"}, 64'(done_cyc), 64'd1);
        else
            chk(done_cyc == last_acc + 2, {tag, " R6 busy fall"}, 64'(done_cyc), 64'(last_acc + 2));
        chk(cfg_rdata == {60'd0, exp_err, mode, 1'b0}, {tag, " R2 R8 status word"},
            cfg_rdata, {60'd0, exp_err, mode, 1'b0});
    endtask

    task automatic run_op(input logic [63:0] s, input logic [63:0] e, input logic [1:0] m,
                          input logic [7:0] rdy, input int exp_n, input logic [39:0] first,
                          input string tag);
        logic [63:0] d;
        wr(5'h00, s);
        wr(5'h08, e);
        rd(5'h00, d);
        chk(d == (s & MASK40), {tag, " R1 start readback"}, d, s & MASK40);
        rd(5'h08, d);
        chk(d == (e & MASK40), {tag, " R1 end readback"}, d, e & MASK40);
        @(negedge clk);
        wr(5'h10, {61'd0, m, 1'b1});
        drain(m, first, exp_n, rdy, 1'b0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] d;
        repeat (3) @(negedge clk);
        // R10: reset state.
        rd(5'h10, d);
        chk(d == 64'd0, "R10 control after reset", d, 64'd0);
        rd(5'h00, d);
        chk(d == 64'd0, "R10 start after reset", d, 64'd0);
        chk(req_valid == 1'b0, "R10 no request in reset", 64'(req_valid), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Table of spans, codes and ready patterns.
        for (int i = 0; i < NV; i++) begin
            run_op(V_START[i], V_END[i], V_MODE[i], V_RDY[i], V_N[i], V_FIRST[i],
                   $sformatf("vec%0d", i));
        end

        // R1: unmapped offset reads zero.
        rd(5'h18, d);
        chk(d == 64'd0, "R1 unmapped offset", d, 64'd0);

        // R8: reserved code sets the error flag and issues nothing.
        @(negedge clk);
        wr(5'h00, 64'h100);
        wr(5'h08, 64'h200);
        wr(5'h10, 64'h7);
        drain(2'd3, 40'h0, 0, 8'hFF, 1'b1, "r8_reserved");
        // R8: next valid start clears the flag.
        run_op(64'h400, 64'h440, 2'd0, 8'hFF, 1, 40'h400, "r8_clear");

        // R2: control write without the start bit changes nothing.
        wr(5'h10, 64'h4);
        rd(5'h10, d);
        chk(d == 64'd0, "R2 write without start bit", d, 64'd0);
        chk(req_valid == 1'b0, "R2 no request without start", 64'(req_valid), 64'd0);

        // R9: writes during a stalled walk are ignored; R5 holds the request.
        wr(5'h00, 64'h8000);
        wr(5'h08, 64'h8400);
        req_ready = 1'b0;
        wr(5'h10, 64'h5);
        wr(5'h00, 64'h9000);
        wr(5'h08, 64'h9100);
        wr(5'h10, 64'h1);
        rd(5'h00, d);
        chk(d == 64'h8000, "R9 start frozen", d, 64'h8000);
        rd(5'h08, d);
        chk(d == 64'h8400, "R9 end frozen", d, 64'h8400);
        rd(5'h10, d);
        chk(d == 64'h5, "R9 control frozen", d, 64'h5);
        chk(req_valid && req_line_addr == 40'h8000 && req_op == 2'd2, "R5 stalled request held",
            64'(req_line_addr), 64'h8000);
        @(negedge clk);
        drain(2'd2, 40'h8000, 16, 8'hFF, 1'b0, "r9_busy_writes");

        // R10: reset in the middle of a walk.
        wr(5'h10, 64'h3);
        chk(req_valid == 1'b1, "R10 walk running before reset", 64'(req_valid), 64'd1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(5'h10, d);
        chk(d == 64'd0, "R10 control after mid-walk reset", d, 64'd0);
        chk(req_valid == 1'b0, "R10 request dropped by reset", 64'(req_valid), 64'd0);
        rd(5'h08, d);
        chk(d == 64'd0, "R10 end cleared by reset", d, 64'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule